// File: doc/BRIEF.md
# Instruction Table Write Guard

This block sits on a simple register write bus in front of a sequencer's instruction table. It decides whether a write aimed at the table reaches the storage. Write protection is controlled by a lock control register. That register obeys a command only when the register write just before it carried a fixed magic value to a separate key register. The same two-step order applies to locking and to unlocking, so one stray write cannot change the protection state.

Each bus write is taken in the cycle its strobe is high. There is no back-pressure: the block is always ready, and a write is either acted on or dropped in that cycle. A table write that is allowed is forwarded one clock later on the table port as a one-cycle enable, with the word index and data. A write that is not allowed never appears on the table port. The lock state and a sticky violation flag are plain status outputs. The flag records any lock command that arrived without the key.

Top module: `tbl_lock_guard`

## Requirements
- R1: After reset the table is unlocked, the violation flag is clear and no table write enable is asserted.
- R2: A write of 0x5AF05AF0 to the key register (address 0x06) arms the lock control register for the next bus write only. Idle cycles in between do not disarm it, and a second correct key write keeps it armed.
- R3: An armed write of 0x1 to the lock control register (address 0x07) sets the locked output in the cycle after the write.
- R4: An armed write of 0x2 to the lock control register clears the locked output in the cycle after the write.
- R5: A write to the lock control register while not armed leaves the lock state unchanged and sets the violation flag in the cycle after the write.
- R6: A key register write with any value other than 0x5AF05AF0 disarms, so a lock command that follows it is ignored and flags a violation.
- R7: Any write to another address between the key and the command disarms, so that command is ignored and flags a violation.
- R8: A write to the table window (addresses 0x80 to 0xFF) while unlocked gives, one cycle later, a one-cycle table write enable with word index equal to address minus 0x80 and the same data.
- R9: A table window write while locked produces no table write enable.
- R10: An armed write of any code other than 0x1 or 0x2 to the lock control register changes nothing, sets no violation, and uses up the arming.
- R11: Writes to addresses outside the key register, the lock control register and the table window have no effect other than disarming.
- R12: The violation flag stays set until reset. Later key-and-command sequences do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Write word address |
| bus_wdata | input | 32 | Write data |
| tbl_we | output | 1 | Table write enable, one cycle per granted write |
| tbl_idx | output | 7 | Table word index |
| tbl_wdata | output | 32 | Table write data |
| locked | output | 1 | Table write protection is active |
| violation | output | 1 | Sticky flag: lock command without the key |

## Verification
An arm flag that stays set too long shows up as a lock or unlock that a disarming write should have blocked. That error appears on `locked` one cycle after the command, and `violation` stays low when it should have risen. An arm flag that is lost shows up the same cycle as a violation with no change of lock state. A wrong lock state shows up on the next table window write, as an enable that is missing or one that should not be there. Random write sequences heavy in key and command values are checked every cycle against a reference model, so a fault appears at the first write that depends on it.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

  // Kind of target a bus write is aimed at.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_KEY  = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_TBL  = 2'd3
  } tgt_e;

endpackage

// File: rtl/tlg_decode.sv
module tlg_decode
  import tlg_pkg::*;
#(
  parameter int AW        = 8,
  parameter int KEY_ADDR  = 6,
  parameter int CTRL_ADDR = 7,
  parameter int TBL_BASE  = 128,
  parameter int TBL_DEPTH = 128,
  localparam int TAW      = $clog2(TBL_DEPTH)
) (
  input  logic [AW-1:0]  addr,
  output tgt_e           kind,
  output logic [TAW-1:0] idx
);

  localparam logic [AW-1:0] BASE_V = AW'(TBL_BASE);

  logic in_tbl;

  always_comb begin
    in_tbl = (int'(addr) >= TBL_BASE) && (int'(addr) < TBL_BASE + TBL_DEPTH);
    if (int'(addr) == KEY_ADDR)       kind = TGT_KEY;
    else if (int'(addr) == CTRL_ADDR) kind = TGT_CTRL;
    else if (in_tbl)                  kind = TGT_TBL;
    else                              kind = TGT_NONE;
    idx = TAW'(addr - BASE_V);
  end

endmodule

// File: rtl/tlg_arm.sv
module tlg_arm #(
  parameter int             DW        = 32,
  parameter logic [DW-1:0]  KEY_VALUE = 32'h5AF0_5AF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          to_key,
  input  logic [DW-1:0] wdata,
  output logic          armed
);

  // Every write re-evaluates the arm flag; idle cycles hold it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed <= 1'b0;
    else if (wr) armed <= to_key && (wdata == KEY_VALUE);
  end

  // R2: the arm flag only rises after a correct key write
  p_arm_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr && to_key && (wdata == KEY_VALUE)));

  // R7: a write that does not target the key register always disarms
  p_arm_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr && !to_key) |=> !armed);

  // R2: without a write the arm flag holds
  p_arm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(armed));

endmodule

// File: rtl/tlg_lock.sv
module tlg_lock #(
  parameter int            DW          = 32,
  parameter logic [DW-1:0] CODE_LOCK   = 32'h1,
  parameter logic [DW-1:0] CODE_UNLOCK = 32'h2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          armed,
  input  logic [DW-1:0] wdata,
  output logic          locked,
  output logic          violation
);

  logic do_lock, do_unlock, bad_cmd;

  always_comb begin
    do_lock   = ctrl_wr && armed && (wdata == CODE_LOCK);
    do_unlock = ctrl_wr && armed && (wdata == CODE_UNLOCK);
    bad_cmd   = ctrl_wr && !armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      violation <= 1'b0;
    end else begin
      if (do_lock)        locked <= 1'b1;
      else if (do_unlock) locked <= 1'b0;
      if (bad_cmd)        violation <= 1'b1;
    end
  end

  // R5: the lock state changes only after an armed command write
  p_change_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(ctrl_wr && armed));

  // R12: once set, the violation flag stays set
  p_viol_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(violation) |-> violation);

  // R5: the violation flag rises only after an unarmed command write
  p_viol_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> $past(ctrl_wr && !armed));

endmodule

// File: rtl/tlg_gate.sv
module tlg_gate #(
  parameter int DW  = 32,
  parameter int TAW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tbl_wr,
  input  logic [TAW-1:0] idx_in,
  input  logic [DW-1:0]  wdata,
  input  logic           locked,
  output logic           we_out,
  output logic [TAW-1:0] idx_out,
  output logic [DW-1:0]  data_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_out   <= 1'b0;
      idx_out  <= '0;
      data_out <= '0;
    end else begin
      we_out <= tbl_wr && !locked;
      if (tbl_wr && !locked) begin
        idx_out  <= idx_in;
        data_out <= wdata;
      end
    end
  end

  // R9: no table write leaves while the table was locked
  p_drop_when_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_out |-> !$past(locked));

  // R8: every enable comes from a table write one cycle earlier
  p_we_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_out |-> $past(tbl_wr));

  // R8: forwarded index and data hold between granted writes
  p_payload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_out |-> ($stable(idx_out) && $stable(data_out)));

endmodule

// File: rtl/tbl_lock_guard.sv
module tbl_lock_guard
  import tlg_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            DW          = 32,
  parameter int            KEY_ADDR    = 6,
  parameter int            CTRL_ADDR   = 7,
  parameter int            TBL_BASE    = 128,
  parameter int            TBL_DEPTH   = 128,
  parameter logic [DW-1:0] KEY_VALUE   = 32'h5AF0_5AF0,
  parameter logic [DW-1:0] CODE_LOCK   = 32'h1,
  parameter logic [DW-1:0] CODE_UNLOCK = 32'h2,
  localparam int           TAW         = $clog2(TBL_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic           tbl_we,
  output logic [TAW-1:0] tbl_idx,
  output logic [DW-1:0]  tbl_wdata,
  output logic           locked,
  output logic           violation
);

  tgt_e           kind;
  logic [TAW-1:0] dec_idx;
  logic           armed;
  logic           key_sel, ctrl_wr, tbl_wr;

  tlg_decode #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .TBL_BASE(TBL_BASE), .TBL_DEPTH(TBL_DEPTH)
  ) u_decode (
    .addr (bus_addr),
    .kind (kind),
    .idx  (dec_idx)
  );

  always_comb begin
    key_sel = (kind == TGT_KEY);
    ctrl_wr = bus_wr && (kind == TGT_CTRL);
    tbl_wr  = bus_wr && (kind == TGT_TBL);
  end

  tlg_arm #(.DW(DW), .KEY_VALUE(KEY_VALUE)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .to_key (key_sel),
    .wdata  (bus_wdata),
    .armed  (armed)
  );

  tlg_lock #(.DW(DW), .CODE_LOCK(CODE_LOCK), .CODE_UNLOCK(CODE_UNLOCK)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .armed     (armed),
    .wdata     (bus_wdata),
    .locked    (locked),
    .violation (violation)
  );

  tlg_gate #(.DW(DW), .TAW(TAW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tbl_wr   (tbl_wr),
    .idx_in   (dec_idx),
    .wdata    (bus_wdata),
    .locked   (locked),
    .we_out   (tbl_we),
    .idx_out  (tbl_idx),
    .data_out (tbl_wdata)
  );

  // R1: idle bus never produces a table write
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !tbl_we);

  // R11: a write outside every decoded target keeps lock and flag steady
  p_other_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == TGT_NONE) |=> ($stable(locked) && $stable(violation) && !tbl_we));

endmodule

// File: tb/tbl_lock_guard_tb.sv
`timescale 1ns/1ps
module tbl_lock_guard_tb;

  localparam logic [7:0]  A_KEY  = 8'h06;
  localparam logic [7:0]  A_CTRL = 8'h07;
  localparam int          BASE   = 128;
  localparam logic [31:0] KEYV   = 32'h5AF0_5AF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        tbl_we;
  logic [6:0]  tbl_idx;
  logic [31:0] tbl_wdata;
  logic        locked, violation;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit m_lock, m_arm, m_viol;

  always #2.5 clk = ~clk;

  tbl_lock_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .locked(locked), .violation(violation)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_tbl(input logic [7:0] a);
    return int'(a) >= BASE;
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [31:0] d);
    if (a == A_KEY)  return (d == KEYV) ? "R2" : "R6";
    if (a == A_CTRL) begin
      if (!m_arm)        return "R5";
      if (d == 32'h1)    return "R3";
      if (d == 32'h2)    return "R4";
      return "R10";
    end
    if (in_tbl(a)) return m_lock ? "R9" : "R8";
    return "R11";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lock = 0; m_arm = 0; m_viol = 0;
    @(negedge clk);
    chk("R1", "locked after reset", {31'b0, locked}, 32'd0);
    chk("R1", "violation after reset", {31'b0, violation}, 32'd0);
    chk("R1", "tbl_we after reset", {31'b0, tbl_we}, 32'd0);
  endtask

  // Drive one write at a falling edge, check outputs at the next falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    bit e_we;
    e_we = in_tbl(a) && !m_lock;
    if (a == A_CTRL) begin
      if (!m_arm)             m_viol = 1;
      else if (d == 32'h1)    m_lock = 1;
      else if (d == 32'h2)    m_lock = 0;
    end
    m_arm = (a == A_KEY) && (d == KEYV);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(tag, "tbl_we", {31'b0, tbl_we}, {31'b0, e_we});
    if (e_we) begin
      chk(tag, "tbl_idx", {25'b0, tbl_idx}, 32'(int'(a) - BASE));
      chk(tag, "tbl_wdata", tbl_wdata, d);
    end
    chk(tag, "locked", {31'b0, locked}, {31'b0, m_lock});
    chk(tag, "violation", {31'b0, violation}, {31'b0, m_viol});
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(tag, "tbl_we idle", {31'b0, tbl_we}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    // R8: unlocked table writes pass, first and last index
    wr(8'h85, 32'hDEAD_BEEF, "R8");
    wr(8'hFF, 32'h0123_4567, "R8");
    wr(8'h80, 32'hCAFE_F00D, "R8");
    // R3: key then lock
    wr(A_KEY, KEYV, "R2");
    wr(A_CTRL, 32'h1, "R3");
    // R9: dropped while locked
    wr(8'h90, 32'h1111_2222, "R9");
    // R5: unlock without key
    wr(A_CTRL, 32'h2, "R5");
    // R4 and R12: proper unlock leaves flag set
    wr(A_KEY, KEYV, "R2");
    wr(A_CTRL, 32'h2, "R4");
    chk("R12", "violation kept", {31'b0, violation}, 32'd1);
    do_reset();
    // R6: wrong key value
    wr(A_KEY, KEYV ^ 32'h1, "R6");
    wr(A_CTRL, 32'h1, "R6");
    do_reset();
    // R7: intervening table write disarms
    wr(A_KEY, KEYV, "R7");
    wr(8'hA0, 32'h5555_AAAA, "R7");
    wr(A_CTRL, 32'h1, "R7");
    do_reset();
    // R2: idle cycles keep arming; repeated key keeps arming
    wr(A_KEY, KEYV, "R2");
    idle("R2"); idle("R2");
    wr(A_CTRL, 32'h1, "R2");
    wr(A_KEY, KEYV, "R2");
    wr(A_KEY, KEYV, "R2");
    wr(A_CTRL, 32'h2, "R2");
    // R10: unknown code consumes arming
    wr(A_KEY, KEYV, "R10");
    wr(A_CTRL, 32'h3, "R10");
    wr(A_CTRL, 32'h1, "R10");
    do_reset();
    // R11: unrelated address disarms, no other effect
    wr(A_KEY, KEYV, "R11");
    wr(8'h10, KEYV, "R11");
    wr(A_CTRL, 32'h1, "R11");
    do_reset();
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0]  a;
      logic [31:0] d;
      sel = int'($urandom % 8);
      d = $urandom;
      case (sel)
        0, 1: begin a = A_KEY; if ($urandom % 4 != 0) d = KEYV; end
        2, 3: begin a = A_CTRL; if ($urandom % 4 != 0) d = 32'(1 + $urandom % 2); end
        4, 5: a = 8'(BASE + int'($urandom % 128));
        6:    a = 8'(8 + int'($urandom % 120));
        default: a = 8'h00;
      endcase
      if (sel == 7) idle("R2");
      else wr(a, d, tag_of(a, d));
      if (i % 1000 == 999) do_reset();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule